// File: doc/BRIEF.md
# Tri-State Address Word Receiver with Two-Word Confirmation

This block sits behind a detector and takes a serial line on which every symbol is sent as two high pulses. It measures each pulse in clock cycles, sorts it as short or long, and turns each pair into a zero, a one or an open symbol. A long stretch of low level ends a word. Each word starts with an address field. The block compares that field, symbol by symbol, with a local tri-state setting. A data field follows the address.

The active-low `valid_n` output has hysteresis. It falls only after two matching words in a row, and it rises only after two non-matching words in a row. The data field reaches `data_out` only when two matching words in a row carry equal data. A mode pin sets what `data_out` does when `valid_n` is released. In momentary mode it is cleared. In latched mode it keeps the last confirmed value.

Top module: `tsw_decoder`

## Requirements
- R1: During and after reset, `valid_n` is 1, `data_out` is 0, and no earlier word counts toward a confirmation.
- R2: A high pulse of at most SHORT_MAX (2) cycles is short, and a longer one is long. A low run of more than GAP_LEN (8) cycles after a pulse ends the word. The outputs update at the clock edge that samples the ninth low cycle. A low run of exactly 8 cycles inside a word does not split it.
- R3: The two pulses of a symbol decode as follows: long then long is zero, short then short is one, long then short is open. Address symbol i is set by `addr_cfg[2i+1:2i]`, where 00 means zero, 01 means one and 10 means open. The first received symbol is address symbol 0.
- R4: A word matches only if every received address symbol equals its setting, including the open setting.
- R5: `valid_n` falls at the end of the second of two consecutive matching words. A single matching word leaves it high.
- R6: `valid_n` rises at the end of the second of two consecutive unmatched words. A single unmatched word between matching words leaves it low.
- R7: The DATA_BITS symbols after the address form the data field. The first of them is the MSB. One and open both give 1, and zero gives 0.
- R8: `data_out` takes a word's data only when that word and the one before it both match and carry equal data. It changes at no other moment, except as R9 states.
- R9: When `latch_mode` is 0 and `valid_n` rises, `data_out` becomes 0 in the same cycle.
- R10: When `latch_mode` is 1, `data_out` keeps its value through a release. It is replaced only by the next confirmed value.
- R11: A short-then-long pulse pair makes the whole word unmatched.
- R12: A word with fewer or more than ADDR_SYMS+DATA_BITS symbols, or with an odd number of pulses, is unmatched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial pulse stream from the detector |
| latch_mode | input | 1 | 0 momentary, 1 latched data output |
| addr_cfg | input | 2*ADDR_SYMS | Local tri-state address, 2 bits per symbol |
| valid_n | output | 1 | Active-low confirmed-match output |
| data_out | output | DATA_BITS | Confirmed data field |

## Verification
Two events fall in the same cycle. When `valid_n` is asserted, the first data transfer happens at the same edge. When `valid_n` is released in momentary mode, `data_out` is cleared at that same edge. Both cases are provoked by sending two identical matching words, and then two unmatched words in momentary mode, and again in latched mode. A behavioural model in the bench knows the exact edge at which each word ends. Both outputs are compared with it on every clock, so an update that lands one cycle early or late, or on only one of the two outputs, shows up as a miscompare.

// File: rtl/tsw_decoder.sv
module tsw_decoder #(
  parameter int ADDR_SYMS = 6,
  parameter int DATA_BITS = 4,
  parameter int SHORT_MAX = 2,
  parameter int GAP_LEN   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_in,
  input  logic                   latch_mode,
  input  logic [2*ADDR_SYMS-1:0] addr_cfg,
  output logic                   valid_n,
  output logic [DATA_BITS-1:0]   data_out
);
  localparam int SYMS = ADDR_SYMS + DATA_BITS;
  localparam int HW   = $clog2(SHORT_MAX + 2);
  localparam int LW   = $clog2(GAP_LEN + 1);
  localparam int IW   = $clog2(SYMS + 2);
  localparam int AW   = $clog2(ADDR_SYMS + 1);
  localparam logic [HW-1:0] H_SAT = HW'(SHORT_MAX + 1);
  localparam logic [HW-1:0] H_SHORT = HW'(SHORT_MAX);
  localparam logic [LW-1:0] L_END = LW'(GAP_LEN);
  localparam logic [IW-1:0] I_END = IW'(SYMS);
  localparam logic [IW-1:0] I_SAT = IW'(SYMS + 1);
  localparam logic [IW-1:0] I_ADDR = IW'(ADDR_SYMS);

  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt;
  logic [IW-1:0] idx;
  logic seen, half, first_long, bad;
  logic prev_ok, prev_bad;
  logic [DATA_BITS-1:0] dsh, prev_data;

  wire pend    = !rx_in && (hcnt != '0);
  wire is_long = hcnt > H_SHORT;
  wire wend    = !rx_in && seen && (lcnt == L_END);
  wire in_addr = idx < I_ADDR;
  wire [AW-1:0] aidx = in_addr ? AW'(idx) : '0;
  wire [1:0] cfg_sym = addr_cfg[2*aidx +: 2];

  logic [1:0] sym;
  always_comb begin
    case ({first_long, is_long})
      2'b11:   sym = 2'b00;
      2'b00:   sym = 2'b01;
      2'b10:   sym = 2'b10;
      default: sym = 2'b11;
    endcase
  end

  wire sym_bad  = (sym == 2'b11) || (in_addr ? (sym != cfg_sym) : (idx >= I_END));
  wire dbit     = (sym != 2'b00);
  wire word_ok  = !bad && !half && (idx == I_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; lcnt <= '0; idx <= '0;
      seen <= 1'b0; half <= 1'b0; first_long <= 1'b0; bad <= 1'b0;
      dsh <= '0;
    end else begin
      if (rx_in) begin
        if (hcnt != H_SAT) hcnt <= hcnt + 1'b1;
        lcnt <= '0;
      end else begin
        hcnt <= '0;
        if (lcnt != L_END) lcnt <= lcnt + 1'b1;
      end
      if (pend) begin
        seen <= 1'b1;
        if (!half) begin
          half       <= 1'b1;
          first_long <= is_long;
        end else begin
          half <= 1'b0;
          if (idx != I_SAT) idx <= idx + 1'b1;
          bad <= bad | sym_bad;
          if (!in_addr && idx < I_END) dsh <= (dsh << 1) | DATA_BITS'(dbit);
        end
      end
      if (wend) begin
        seen <= 1'b0; half <= 1'b0; idx <= '0; bad <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_n <= 1'b1; data_out <= '0;
      prev_ok <= 1'b0; prev_bad <= 1'b0; prev_data <= '0;
    end else if (wend) begin
      if (word_ok) begin
        if (prev_ok) begin
          valid_n <= 1'b0;
          if (dsh == prev_data) data_out <= dsh;
        end
        prev_ok   <= 1'b1;
        prev_bad  <= 1'b0;
        prev_data <= dsh;
      end else begin
        if (prev_bad) begin
          valid_n <= 1'b1;
          if (!latch_mode) data_out <= '0;
        end
        prev_bad <= 1'b1;
        prev_ok  <= 1'b0;
      end
    end
  end

  p_assert_after_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_n) |-> $past(prev_ok) && $past(wend));
  p_release_after_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_n) |-> $past(prev_bad) && $past(wend));
  p_data_moves_at_word_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> $past(wend));
  p_momentary_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_n) && !$past(latch_mode) |-> data_out == '0);
  p_latched_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_n) && $past(latch_mode) |-> $stable(data_out));
endmodule

// File: tb/tb_tsw_decoder.sv
`timescale 1ns/1ps
module tb_tsw_decoder;
  localparam int AS = 6, DB = 4, GAP = 8, SYMS = AS + DB;

  logic clk = 0, rst_n = 0, rx = 0, latch_mode = 0, run = 0;
  logic [2*AS-1:0] addr_cfg;
  logic valid_n;
  logic [DB-1:0] data_out;

  tsw_decoder #(.ADDR_SYMS(AS), .DATA_BITS(DB), .SHORT_MAX(2), .GAP_LEN(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .latch_mode(latch_mode),
    .addr_cfg(addr_cfg), .valid_n(valid_n), .data_out(data_out));

  always #5 clk = ~clk;

  int cfg[AS] = '{0, 1, 2, 1, 0, 2};
  int vectors = 0, miscompares = 0, k = 0;
  string cur_req = "R1";
  logic exp_valid_n = 1;
  logic [DB-1:0] exp_data = '0, m_prev_data = '0;
  bit m_prev_ok = 0, m_prev_bad = 0;
  int word[$];

  always @(posedge clk) begin
    #2;
    if (run) begin
      vectors++;
      if (valid_n !== exp_valid_n || data_out !== exp_data) begin
        miscompares++;
        $display("FAIL %s cycle: valid_n=%b exp %b, data_out=%h exp %h",
                 cur_req, valid_n, exp_valid_n, data_out, exp_data);
      end
    end
  end

  task automatic chk(string req);
    vectors++;
    if (valid_n !== exp_valid_n || data_out !== exp_data) begin
      miscompares++;
      $display("FAIL %s: valid_n=%b exp %b, data_out=%h exp %h",
               req, valid_n, exp_valid_n, data_out, exp_data);
    end
  endtask

  task automatic model_word(bit odd);
    bit ok = !odd && word.size() == SYMS;
    logic [DB-1:0] d = '0;
    if (ok) begin
      for (int i = 0; i < SYMS; i++) begin
        if (word[i] == 3) ok = 0;
        if (i < AS && word[i] != cfg[i]) ok = 0;
        if (i >= AS) d = {d[DB-2:0], word[i] != 0};
      end
    end
    if (ok) begin
      if (m_prev_ok) begin
        exp_valid_n = 0;
        if (d == m_prev_data) exp_data = d;
      end
      m_prev_ok = 1; m_prev_bad = 0; m_prev_data = d;
    end else begin
      if (m_prev_bad) begin
        exp_valid_n = 1;
        if (!latch_mode) exp_data = '0;
      end
      m_prev_bad = 1; m_prev_ok = 0;
    end
  endtask

  task automatic send(bit odd = 0, bit wide_gap = 0);
    int pw[$];
    foreach (word[i]) begin
      k++;
      case (word[i])
        0: begin pw.push_back(3 + k % 3); pw.push_back(3 + (k + 1) % 3); end
        1: begin pw.push_back(1 + k % 2); pw.push_back(1 + (k + 1) % 2); end
        2: begin pw.push_back(3 + k % 3); pw.push_back(1 + k % 2); end
        default: begin pw.push_back(1 + k % 2); pw.push_back(3 + k % 3); end
      endcase
    end
    if (odd) pw.push_back(2);
    foreach (pw[i]) begin
      rx = 1; repeat (pw[i]) @(negedge clk);
      rx = 0;
      if (i != pw.size() - 1)
        repeat ((wide_gap && i == 2) ? GAP : 1 + i % 3) @(negedge clk);
    end
    repeat (GAP) @(negedge clk);
    model_word(odd);
    repeat (4) @(negedge clk);
  endtask

  task automatic mk(int d3, int d2, int d1, int d0);
    word = {};
    foreach (cfg[i]) word.push_back(cfg[i]);
    word.push_back(d3); word.push_back(d2); word.push_back(d1); word.push_back(d0);
  endtask

  initial begin
    #1500000;
    miscompares++;
    $display("FAIL watchdog: run still busy, expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    foreach (cfg[i]) addr_cfg[2*i +: 2] = 2'(cfg[i]);
    repeat (3) @(negedge clk);
    cur_req = "R1"; chk("R1");
    rst_n = 1; run = 1;
    repeat (12) @(negedge clk); chk("R1");

    cur_req = "R5"; mk(1, 0, 1, 0); send(); chk("R5");
    mk(1, 0, 1, 0); send(0, 1); chk("R5"); chk("R2");
    cur_req = "R8"; mk(0, 1, 1, 0); send(); chk("R8");
    mk(0, 1, 1, 0); send(); chk("R8");
    cur_req = "R4"; mk(0, 1, 1, 0); word[2] = 1; send(); chk("R4");
    cur_req = "R6"; mk(0, 1, 1, 0); send(); mk(0, 1, 1, 0); word[0] = 1; send(); chk("R6");
    mk(0, 1, 1, 0); word[5] = 0; send(); chk("R6");
    cur_req = "R9"; chk("R9");

    latch_mode = 1;
    cur_req = "R7"; mk(2, 0, 2, 1); send(); mk(2, 0, 2, 1); send(); chk("R7"); chk("R3");
    cur_req = "R10"; word[0] = 1; send(); send(); chk("R10");
    mk(0, 0, 1, 1); send(); chk("R10");
    mk(0, 0, 1, 1); send(); chk("R10");
    cur_req = "R11"; mk(0, 0, 1, 1); word[7] = 3; send(); send(); chk("R11");
    cur_req = "R12"; mk(1, 1, 1, 1); send(); send(); chk("R12");
    word.pop_back(); send(); send(); chk("R12");
    mk(1, 1, 1, 1); send(); send(); chk("R12");
    word.push_back(0); send(); send(); chk("R12");
    mk(1, 1, 1, 1); send(); send(); chk("R12");
    send(1); send(1); chk("R12");

    latch_mode = 0;
    cur_req = "R9"; mk(1, 1, 0, 0); send(); send(); chk("R9");
    word[1] = 2; send(); send(); chk("R9");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule